// File: doc/BRIEF.md
# USB Link Activity LED Controller

This block drives one active-low indicator LED so that it shows the state of a USB device link. It is given four inputs: a single-cycle pulse for each transaction the device acknowledged, a level saying the device has been configured, a level saying the link is suspended, and a single-cycle bus-reset pulse. It does not watch the bus itself. It only turns these inputs into the pattern the LED shows.

Before configuration the LED rests dark and flashes on for each acknowledged transaction, so enumeration traffic is visible. Once the device is configured the LED stays lit, and each acknowledged transfer flashes it dark. Suspend forces the LED dark and overrides everything else. A flash lasts a fixed number of clock cycles, set by the `BLINK_CYCLES` parameter. The default is 10,000,000 cycles, which is 50 ms at 200 MHz. A new event during a flash starts the full flash length again.

Top module: `link_led_ctrl`

## Requirements
- R1: After reset `led_n` is 1, the block is in the unconfigured mode and no flash is pending.
- R2: In the unconfigured mode an `ack_pulse` sampled at clock edge k drives `led_n` to 0 from edge k+1 for exactly `BLINK_CYCLES` cycles. After that `led_n` returns to 1.
- R3: A 0-to-1 change of `configured` while not suspended moves the block to the configured mode. From the following edge on, `led_n` is held at 0.
- R4: In the configured mode an `ack_pulse` drives `led_n` to 1 for exactly `BLINK_CYCLES` cycles, with the same timing as R2. After that `led_n` returns to 0.
- R5: An `ack_pulse` that arrives during a flash starts the flash again at its full `BLINK_CYCLES` length.
- R6: While `suspended` is 1, `led_n` is 1 from the edge after suspend is sampled. `ack_pulse` has no effect: no flash is pending when suspend ends.
- R7: When `suspended` returns to 0, the block shows the mode it held before suspend, from the next edge on. Any flash that was running when suspend began is cancelled.
- R8: A `bus_reset` pulse while not suspended returns the block to the unconfigured mode. `configured` must then fall and rise again before the block re-enters the configured mode.
- R9: `configured` at 0 while in the configured mode and not suspended returns the block to the unconfigured mode.
- R10: A mode change cancels any flash in progress. If it comes in the same cycle as an `ack_pulse`, the mode change wins and no flash starts.
- R11: While suspended, `bus_reset` and changes of `configured` do not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ack_pulse | input | 1 | One-cycle pulse per acknowledged transaction |
| configured | input | 1 | Level: device has been configured |
| suspended | input | 1 | Level: link is suspended |
| bus_reset | input | 1 | One-cycle pulse on a USB bus reset |
| led_n | output | 1 | Active-low LED drive |

## Verification
The assertions check on every cycle that:
- the flash counter never exceeds its load value;
- an accepted event reloads the counter to its full length;
- a bus reset outside suspend leaves the unconfigured mode;
- suspend holds the mode;
- a sustained suspend keeps the LED dark;
- the LED level matches the mode whenever no flash runs.

Only the bench scenarios can show the exact flash length, the restart on a retrigger, and that a configured level held through a bus reset does not re-enter the configured mode. The same applies to restoring the mode after suspend with the earlier flash gone.

// File: rtl/led_link_pkg.sv
// Shared types for the link activity LED controller.
package led_link_pkg;

    // Link display mode: unconfigured flashes on, configured flashes off.
    typedef enum logic {
        MODE_ENUM = 1'b0,
        MODE_CONF = 1'b1
    } link_mode_e;

endpackage

// File: rtl/link_mode_fsm.sv
// Link mode tracker.
// Tracks whether the LED shows the unconfigured or the configured pattern.
// Assumes configured is synchronous to clk and bus_reset is one cycle wide.
// While hold is high the mode is frozen. The configured edge detector keeps
// sampling while frozen, so a rise seen during hold is not replayed later.
module link_mode_fsm
    import led_link_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_lvl,
    input  logic       bus_reset,
    input  logic       hold,
    output link_mode_e mode,
    output logic       mode_chg
);

    link_mode_e mode_q;
    link_mode_e mode_d;
    logic       cfg_prev_q;
    logic       cfg_rise;

    assign cfg_rise = cfg_lvl && !cfg_prev_q;

    // Next mode: hold, then bus reset, then a low level, then a rising edge.
    always_comb begin
        mode_d = mode_q;
        if (!hold) begin
            if (bus_reset) begin
                mode_d = MODE_ENUM;
            end else if (!cfg_lvl) begin
                mode_d = MODE_ENUM;
            end else if (cfg_rise) begin
                mode_d = MODE_CONF;
            end
        end
    end

    // Mode register and configured-level history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MODE_ENUM;
            cfg_prev_q <= 1'b0;
        end else begin
            mode_q     <= mode_d;
            cfg_prev_q <= cfg_lvl;
        end
    end

    assign mode     = mode_q;
    assign mode_chg = (mode_d != mode_q);

endmodule

// File: rtl/blink_timer.sv
// Flash stretch timer.
// Produces a flash window of exactly BLINK_CYCLES cycles after a load.
// clear has priority over load. A load during a window restarts it.
module blink_timer #(
    parameter int BLINK_CYCLES = 10_000_000,
    localparam int CW          = $clog2(BLINK_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          clear,
    output logic          active,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] LOAD_VAL = CW'(BLINK_CYCLES);

    logic [CW-1:0] cnt_q;

    // Down-counter: clear, reload, or step toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign active = (cnt_q != '0);
    assign count  = cnt_q;

endmodule

// File: rtl/led_driver.sv
// Registered active-low LED output stage.
// Lit level is the mode inverted by a running flash, and forced dark when
// suspended. Assumes all inputs come from registers.
module led_driver
    import led_link_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  link_mode_e mode,
    input  logic       flash,
    input  logic       dark,
    output logic       led_n
);

    logic lit;
    logic led_n_q;

    assign lit = !dark && ((mode == MODE_CONF) ^ flash);

    // Output flop keeps the pad glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_n_q <= 1'b1;
        end else begin
            led_n_q <= !lit;
        end
    end

    assign led_n = led_n_q;

endmodule

// File: rtl/link_led_ctrl.sv
// Top: USB link activity LED controller.
// Connects the mode tracker, the flash timer and the output stage.
// Assumes all inputs are synchronous to clk.
// Suspend is sampled once for the output path. The raw level freezes the
// mode and clears the timer.
module link_led_ctrl
    import led_link_pkg::*;
#(
    parameter int BLINK_CYCLES = 10_000_000,
    localparam int CW          = $clog2(BLINK_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_pulse,
    input  logic configured,
    input  logic suspended,
    input  logic bus_reset,
    output logic led_n
);

    link_mode_e    mode;
    logic          mode_chg;
    logic          flash;
    logic [CW-1:0] flash_cnt;
    logic          susp_q;
    logic          tmr_load;
    logic          tmr_clear;

    // Suspend sample for the output path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            susp_q <= 1'b0;
        end else begin
            susp_q <= suspended;
        end
    end

    assign tmr_load  = ack_pulse && !suspended;
    assign tmr_clear = suspended || mode_chg;

    link_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_lvl   (configured),
        .bus_reset (bus_reset),
        .hold      (suspended),
        .mode      (mode),
        .mode_chg  (mode_chg)
    );

    blink_timer #(.BLINK_CYCLES(BLINK_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .clear  (tmr_clear),
        .active (flash),
        .count  (flash_cnt)
    );

    led_driver u_drv (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .flash (flash),
        .dark  (susp_q),
        .led_n (led_n)
    );

endmodule

// File: rtl/link_led_ctrl_chk.sv
// Assertion checker bound to link_led_ctrl.
module link_led_ctrl_chk
    import led_link_pkg::*;
#(
    parameter int BLINK_CYCLES = 10_000_000,
    localparam int CW          = $clog2(BLINK_CYCLES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack_pulse,
    input logic          suspended,
    input logic          bus_reset,
    input logic          mode_chg,
    input logic          susp_q,
    input link_mode_e    mode,
    input logic [CW-1:0] flash_cnt,
    input logic          led_n
);

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flash_cnt <= CW'(BLINK_CYCLES));

    // R2
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_pulse && !suspended && !mode_chg) |=> (flash_cnt == CW'(BLINK_CYCLES)));

    // R8
    bus_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reset && !suspended) |=> (mode == MODE_ENUM));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspended |=> $stable(mode));

    // R6
    dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (suspended && susp_q) |=> led_n);

    // R1
    rest_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ENUM && flash_cnt == '0 && !susp_q) |=> led_n);

    // R3
    rest_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CONF && flash_cnt == '0 && !susp_q) |=> !led_n);

endmodule

bind link_led_ctrl link_led_ctrl_chk #(.BLINK_CYCLES(BLINK_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_pulse (ack_pulse),
    .suspended (suspended),
    .bus_reset (bus_reset),
    .mode_chg  (mode_chg),
    .susp_q    (susp_q),
    .mode      (mode),
    .flash_cnt (flash_cnt),
    .led_n     (led_n)
);

// File: tb/tb_link_led_ctrl.sv
module tb_link_led_ctrl;

    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ack_pulse = 1'b0;
    logic configured = 1'b0;
    logic suspended = 1'b0;
    logic bus_reset = 1'b0;
    logic led_n;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    link_led_ctrl #(.BLINK_CYCLES(N)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_pulse  (ack_pulse),
        .configured (configured),
        .suspended  (suspended),
        .bus_reset  (bus_reset),
        .led_n      (led_n)
    );

    task automatic check(input int act, input int exp, input string req);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: wait to the next falling edge.
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        ack_pulse = 1'b1; tick(); ack_pulse = 1'b0;
    endtask

    // Count consecutive samples at level v, starting from the next cycle.
    task automatic run_len(input logic v, output int len);
        len = 0;
        for (int i = 0; i < 4 * N; i++) begin
            tick();
            if (led_n !== v) break;
            len++;
        end
    endtask

    // Verify led_n stays at v for c cycles.
    task automatic hold_level(input logic v, input int c, input string req);
        int bad = 0;
        for (int i = 0; i < c; i++) begin
            tick();
            if (led_n !== v) bad++;
        end
        check(bad, 0, req);
    endtask

    task automatic t_reset();
        check(led_n, 1, "R1 reset level");
        hold_level(1'b1, 5, "R1 idle after reset");
    endtask

    task automatic t_enum_flash();
        int len;
        pulse_ack();
        run_len(1'b0, len);
        check(len, N, "R2 flash-on length");
        check(led_n, 1, "R2 back to dark");
        tick();
    endtask

    task automatic t_retrigger();
        int len;
        pulse_ack();
        tick(); tick(); tick();
        check(led_n, 0, "R5 lit mid flash");
        pulse_ack();
        run_len(1'b0, len);
        check(len, N, "R5 restarted length");
        tick();
    endtask

    task automatic t_configure();
        configured = 1'b1; tick(); tick();
        check(led_n, 0, "R3 lit when configured");
        hold_level(1'b0, 20, "R3 steady on");
    endtask

    task automatic t_conf_flash();
        int len;
        pulse_ack();
        run_len(1'b1, len);
        check(len, N, "R4 flash-off length");
        check(led_n, 0, "R4 back to lit");
        tick();
    endtask

    task automatic t_cfg_drop_priority();
        configured = 1'b0; ack_pulse = 1'b1; tick();
        ack_pulse = 1'b0; tick();
        check(led_n, 1, "R9 unconfigured after drop");
        hold_level(1'b1, 12, "R10 no flash on mode change");
    endtask

    task automatic t_bus_reset();
        configured = 1'b1; tick(); tick();
        check(led_n, 0, "R3 re-configured");
        pulse_ack(); tick(); tick();
        bus_reset = 1'b1; tick(); bus_reset = 1'b0;
        hold_level(1'b1, 12, "R8 unconfigured with level held");
        configured = 1'b0; tick(); configured = 1'b1; tick(); tick();
        check(led_n, 0, "R8 new rise configures");
        tick();
    endtask

    task automatic t_suspend_conf();
        pulse_ack(); tick();
        suspended = 1'b1; tick(); tick();
        check(led_n, 1, "R6 dark in suspend");
        pulse_ack();
        bus_reset = 1'b1; tick(); bus_reset = 1'b0;
        hold_level(1'b1, 10, "R6 acks ignored in suspend");
        suspended = 1'b0; tick(); tick();
        check(led_n, 0, "R11 mode kept over bus reset in suspend");
        hold_level(1'b0, 12, "R7 no pending flash after suspend");
    endtask

    task automatic t_suspend_enum();
        configured = 1'b0; tick(); tick();
        check(led_n, 1, "R9 unconfigured");
        pulse_ack(); tick();
        suspended = 1'b1;
        configured = 1'b1; tick(); tick();
        check(led_n, 1, "R6 dark in suspend");
        tick(); tick();
        suspended = 1'b0; tick();
        hold_level(1'b1, 12, "R7 unconfigured restored, flash cancelled");
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_enum_flash();
        t_retrigger();
        t_configure();
        t_conf_flash();
        t_cfg_drop_priority();
        t_bus_reset();
        t_suspend_conf();
        t_suspend_enum();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule